// File: doc/BRIEF.md
# 66-to-16 Transmit Gearbox

This block sits between a 64b/66b block encoder (with its scrambler) and a 16-bit serializer. Each input item is a 66-bit coded block: a 2-bit sync header that marks the block as data or control, and 64 payload bits that have already been scrambled upstream. The gearbox passes the payload through unchanged. It sends the bits out as a steady stream of 16-bit words, one word per clock whenever it holds enough bits.

A block is 66 bits and a word is 16 bits, so blocks do not split evenly into words. Bits left over from one block wait in a residue buffer with a bit count. The block asks for a new block only when the bits it still holds after the current word would not fill the next word. With a source that is always ready, eight blocks leave as exactly 33 words with no gap. The sync header must always contain a transition. A block whose header has no transition is still sent, but it sets a sticky error flag.

Top module: `gbx_tx_66_16`

## Requirements
- R1: The serial order of a block is hdr[0], then hdr[1], then payload[0] up to payload[63]. Bit 0 of each output word is the earliest of its 16 bits. Payload bits leave unchanged.
- R2: A block is taken on a rising clock edge where blk_valid and blk_ready are both high, and only then.
- R3: blk_ready is high exactly when the residue, less the 16 bits sent in this cycle (if a word is sent), holds fewer than 16 bits. After a lone block is taken into an empty buffer, blk_ready reads 0, 0, 0, 1, 1 on the next five cycles.
- R4: A word is sent on an edge where the residue holds at least 16 bits. word_valid rises after that edge and word_data carries the next 16 bits in stream order.
- R5: After reset the residue is empty, word_valid and hdr_err are 0 and blk_ready is 1. No word is marked valid until a block has been taken. The first word appears on the second edge after the block is taken.
- R6: With blk_valid held high, 8 blocks come out as exactly 33 words on 33 consecutive cycles.
- R7: A taken block whose header is 2'b00 or 2'b11 sets hdr_err on the edge that takes it, and all 66 of its bits are still sent. Legal headers are 2'b01 (data) and 2'b10 (control).
- R8: hdr_err stays set until reset.
- R9: When input stalls, word_valid drops while the residue holds fewer than 16 bits. No bit is lost or repeated across such gaps.
- R10: Data on the block inputs while blk_ready is low has no effect on the output stream or on hdr_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| blk_valid | input | 1 | Block present on the inputs |
| blk_ready | output | 1 | Gearbox takes a block on this edge if offered |
| blk_hdr | input | 2 | Sync header of the block |
| blk_payload | input | 64 | Scrambled payload of the block |
| word_valid | output | 1 | word_data holds a new 16-bit word |
| word_data | output | 16 | Output word, bit 0 earliest |
| hdr_err | output | 1 | Sticky flag: a block with an illegal header was taken |

## Verification
The bench feeds blocks back to back so that the residue walks through every offset of the 33-word cycle. A design that stalls at a wrap point shows a gap in the 33-cycle run. A design that misplaces the new block against the leftover bits shows a shifted word. Random gaps between blocks drive the residue below a full word, where a design that drops or repeats bits around a bubble fails the bitwise scoreboard. While blk_ready is low the bench drives junk blocks with an illegal header, so a design that takes data it did not ask for corrupts the stream and raises hdr_err. Illegal headers and a reset in the middle of the stream check that the flag holds until reset and that the block with the bad header still goes out.

// File: rtl/gbx_pkg.sv
package gbx_pkg;

    // Default geometry of the gearbox
    localparam int GB_HDR_W  = 2;
    localparam int GB_PAY_W  = 64;
    localparam int GB_WORD_W = 16;

    // Legal sync header values: each carries a transition
    typedef enum logic [1:0] {
        GB_HDR_DATA = 2'b01,
        GB_HDR_CTRL = 2'b10
    } gb_hdr_e;

    // Per-cycle decision of the residue buffer
    typedef struct packed {
        logic take;    // a word leaves the buffer on this edge
        logic accept;  // a block enters the buffer on this edge
    } gb_step_t;

    // A header is legal when exactly one of its bits is set
    function automatic logic gb_hdr_legal(input logic [GB_HDR_W-1:0] h);
        return $onehot(h);
    endfunction

endpackage

// File: rtl/gbx_residue.sv
module gbx_residue
    import gbx_pkg::*;
#(
    parameter int BLK_W  = GB_HDR_W + GB_PAY_W,
    parameter int WORD_W = GB_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BLK_W-1:0]  in_bits,
    output logic              in_ready,
    output logic              take,
    output logic              accept,
    output logic [WORD_W-1:0] head
);

    localparam int BUF_W = BLK_W + WORD_W - 1;
    localparam int CNT_W = $clog2(BUF_W + 1);

    logic [BUF_W-1:0] bits_q, bits_d, shifted, incoming;
    logic [CNT_W-1:0] cnt_q, cnt_d, rem;
    gb_step_t         step;

    always_comb begin
        step.take   = cnt_q >= CNT_W'(WORD_W);
        rem         = step.take ? cnt_q - CNT_W'(WORD_W) : cnt_q;
        in_ready    = rem < CNT_W'(WORD_W);
        step.accept = in_valid && in_ready;
        shifted     = step.take ? (bits_q >> WORD_W) : bits_q;
        incoming    = BUF_W'(in_bits) << rem;
        bits_d      = step.accept ? (shifted | incoming) : shifted;
        cnt_d       = step.accept ? rem + CNT_W'(BLK_W) : rem;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
            cnt_q  <= '0;
        end else begin
            bits_q <= bits_d;
            cnt_q  <= cnt_d;
        end
    end

    assign take   = step.take;
    assign accept = step.accept;
    assign head   = bits_q[WORD_W-1:0];

    // R4: the count never exceeds the buffer
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(BUF_W));

    // R3: two full words held means no room asked for
    p_full_stalls_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt_q >= CNT_W'(2 * WORD_W)) |-> !in_ready);

    // R5: an empty buffer always asks for a block
    p_empty_asks_r5: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0) |-> in_ready);

    // R9: the count moves only by whole words and whole blocks
    p_bits_conserved_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt_q == $past(cnt_q)) ||
                 (cnt_q + CNT_W'(WORD_W) == $past(cnt_q)) ||
                 (cnt_q == $past(cnt_q) + CNT_W'(BLK_W)) ||
                 (cnt_q + CNT_W'(WORD_W) == $past(cnt_q) + CNT_W'(BLK_W)));

    // R9: no stale bits above the count
    p_no_stale_bits_r9: assert property (@(posedge clk) disable iff (rst)
        (bits_q >> cnt_q) == '0);

endmodule

// File: rtl/gbx_word_reg.sv
module gbx_word_reg
    import gbx_pkg::*;
#(
    parameter int WORD_W = GB_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [WORD_W-1:0] head,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_valid <= 1'b0;
            word_data  <= '0;
        end else begin
            word_valid <= take;
            if (take) begin
                word_data <= head;
            end
        end
    end

    // R4: a stalled output holds its last word
    p_hold_when_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(word_data));

endmodule

// File: rtl/gbx_hdr_check.sv
module gbx_hdr_check
    import gbx_pkg::*;
#(
    parameter int HDR_W = GB_HDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [HDR_W-1:0] hdr,
    output logic             err
);

    logic bad;

    always_comb bad = accept && !gb_hdr_legal(hdr);

    always_ff @(posedge clk) begin
        if (rst) begin
            err <= 1'b0;
        end else if (bad) begin
            err <= 1'b1;
        end
    end

    // R7: an illegal header that is taken raises the flag
    p_bad_hdr_flags_r7: assert property (@(posedge clk) disable iff (rst)
        (accept && !$onehot(hdr)) |=> err);

    // R8: the flag is sticky
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R10: headers offered while not accepted leave the flag alone
    p_idle_no_flag_r10: assert property (@(posedge clk) disable iff (rst)
        (!accept && !err) |=> !err);

endmodule

// File: rtl/gbx_tx_66_16.sv
module gbx_tx_66_16
    import gbx_pkg::*;
#(
    parameter int HDR_W  = GB_HDR_W,
    parameter int PAY_W  = GB_PAY_W,
    parameter int WORD_W = GB_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              blk_valid,
    output logic              blk_ready,
    input  logic [HDR_W-1:0]  blk_hdr,
    input  logic [PAY_W-1:0]  blk_payload,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data,
    output logic              hdr_err
);

    localparam int BLK_W = HDR_W + PAY_W;

    logic [BLK_W-1:0]  blk_bits;
    logic [WORD_W-1:0] head;
    logic              take;
    logic              accept;

    // Header occupies the low bits so it leaves first
    assign blk_bits = {blk_payload, blk_hdr};

    gbx_residue #(
        .BLK_W  (BLK_W),
        .WORD_W (WORD_W)
    ) u_residue (
        .clk      (clk),
        .rst      (rst),
        .in_valid (blk_valid),
        .in_bits  (blk_bits),
        .in_ready (blk_ready),
        .take     (take),
        .accept   (accept),
        .head     (head)
    );

    gbx_word_reg #(
        .WORD_W (WORD_W)
    ) u_word (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .head       (head),
        .word_valid (word_valid),
        .word_data  (word_data)
    );

    gbx_hdr_check #(
        .HDR_W (HDR_W)
    ) u_hdr (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .hdr    (blk_hdr),
        .err    (hdr_err)
    );

    // Checker state: has any block been taken since reset
    logic seen_blk;
    always_ff @(posedge clk) begin
        if (rst) begin
            seen_blk <= 1'b0;
        end else if (blk_valid && blk_ready) begin
            seen_blk <= 1'b1;
        end
    end

    // R5: silent output until the first block is taken
    p_quiet_before_block_r5: assert property (@(posedge clk) disable iff (rst)
        !seen_blk |-> !word_valid);

    // R2, R4: a taken block produces a word two edges later
    p_accept_yields_word_r4: assert property (@(posedge clk) disable iff (rst)
        (blk_valid && blk_ready) |-> ##2 word_valid);

    // R2: the internal accept matches the port handshake
    p_handshake_r2: assert property (@(posedge clk) disable iff (rst)
        accept == (blk_valid && blk_ready));

endmodule

// File: tb/tb_gbx_tx_66_16.sv
module tb_gbx_tx_66_16;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst;
    logic        blk_valid;
    logic        blk_ready;
    logic [1:0]  blk_hdr;
    logic [63:0] blk_payload;
    logic        word_valid;
    logic [15:0] word_data;
    logic        hdr_err;

    gbx_tx_66_16 dut (
        .clk         (clk),
        .rst         (rst),
        .blk_valid   (blk_valid),
        .blk_ready   (blk_ready),
        .blk_hdr     (blk_hdr),
        .blk_payload (blk_payload),
        .word_valid  (word_valid),
        .word_data   (word_data),
        .hdr_err     (hdr_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    int mon_words, first_cyc, last_cyc;
    bit exp_q[$];
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Monitor: pops 16 expected bits per valid word (R1, R4, R9)
    always @(negedge clk) begin
        if (!rst && word_valid) begin
            logic [15:0] exp_w;
            bit short_q;
            short_q = exp_q.size() < 16;
            exp_w = '0;
            for (int i = 0; i < 16; i++) begin
                if (exp_q.size() > 0) exp_w[i] = exp_q.pop_front();
            end
            check(!short_q && word_data === exp_w, "R1/R9", "word bits",
                  word_data, exp_w);
            if (first_cyc < 0) first_cyc = cyc;
            last_cyc = cyc;
            mon_words++;
        end
    end

    // Driver: offers a block; junk with an illegal header while not ready (R10)
    task automatic send_blk(input logic [1:0] h, input logic [63:0] p);
        bit done = 0;
        while (!done) begin
            blk_valid = 1'b1;
            if (blk_ready) begin
                blk_hdr     = h;
                blk_payload = p;
                for (int i = 0; i < 2; i++)  exp_q.push_back(h[i]);
                for (int i = 0; i < 64; i++) exp_q.push_back(p[i]);
                @(posedge clk);
                @(negedge clk);
                blk_valid = 1'b0;
                done = 1;
            end else begin
                blk_hdr     = 2'b11;
                blk_payload = {$urandom, $urandom};
                @(posedge clk);
                @(negedge clk);
            end
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 400 && exp_q.size() >= 16; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_mon();
        mon_words = 0;
        first_cyc = -1;
        last_cyc  = -1;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected <%0d cycles", WATCHDOG, WATCHDOG);
        finish_run();
    end

    initial begin
        int acc_cyc;
        rst = 1'b1;
        blk_valid = 1'b0;
        blk_hdr = 2'b01;
        blk_payload = '0;
        clear_mon();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R5: reset state
        check(blk_ready === 1'b1, "R5", "ready after reset", blk_ready, 1);
        check(word_valid === 1'b0, "R5", "valid after reset", word_valid, 0);
        check(hdr_err === 1'b0, "R5", "err after reset", hdr_err, 0);

        // R5 latency, then R6 continuous burst of 8 blocks
        clear_mon();
        send_blk(2'b01, 64'h0123_4567_89AB_CDEF);
        acc_cyc = cyc;
        check(word_valid === 1'b0, "R5", "no word right after accept", word_valid, 0);
        for (int b = 1; b < 8; b++)
            send_blk(b[0] ? 2'b10 : 2'b01, {$urandom, $urandom});
        drain();
        check(first_cyc == acc_cyc + 1, "R5", "first word latency", first_cyc, acc_cyc + 1);
        check(mon_words == 33, "R6", "words per 8 blocks", mon_words, 33);
        check(last_cyc - first_cyc + 1 == 33, "R6", "gapless span",
              last_cyc - first_cyc + 1, 33);
        check(hdr_err === 1'b0, "R10", "junk while stalled ignored", hdr_err, 0);
        check(exp_q.size() == 0, "R9", "residue empty", exp_q.size(), 0);
        check(blk_ready === 1'b1, "R3", "ready when empty", blk_ready, 1);

        // R3 ready pattern for a lone block, R9 bubble
        send_blk(2'b10, 64'hFFFF_0000_A5A5_5A5A);
        check(blk_ready === 1'b0, "R3", "ready at 66", blk_ready, 0);
        @(negedge clk);
        check(blk_ready === 1'b0, "R3", "ready at 50", blk_ready, 0);
        @(negedge clk);
        check(blk_ready === 1'b0, "R3", "ready at 34", blk_ready, 0);
        @(negedge clk);
        check(blk_ready === 1'b1, "R3", "ready at 18", blk_ready, 1);
        @(negedge clk);
        check(blk_ready === 1'b1, "R3", "ready at 2", blk_ready, 1);
        check(word_valid === 1'b1, "R4", "fourth word valid", word_valid, 1);
        @(negedge clk);
        check(word_valid === 1'b0, "R9", "bubble with 2 bits left", word_valid, 0);

        // R9 random gaps between blocks
        for (int b = 0; b < 24; b++) begin
            send_blk(($urandom % 2) ? 2'b10 : 2'b01, {$urandom, $urandom});
            repeat ($urandom % 4) @(negedge clk);
        end
        drain();
        check(exp_q.size() < 16, "R9", "gappy stream drained", exp_q.size(), 0);

        // R7 illegal headers still sent, R8 sticky
        check(hdr_err === 1'b0, "R7", "err clear before bad header", hdr_err, 0);
        send_blk(2'b00, 64'hDEAD_BEEF_0000_1111);
        check(hdr_err === 1'b1, "R7", "err after header 00", hdr_err, 1);
        for (int b = 0; b < 3; b++) send_blk(2'b01, {$urandom, $urandom});
        check(hdr_err === 1'b1, "R8", "err stays set", hdr_err, 1);
        send_blk(2'b11, 64'h1357_9BDF_2468_ACE0);
        drain();
        check(hdr_err === 1'b1, "R8", "err still set after drain", hdr_err, 1);

        // R5, R8 reset mid-stream clears everything
        rst = 1'b1;
        exp_q.delete();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(hdr_err === 1'b0, "R8", "err cleared by reset", hdr_err, 0);
        check(word_valid === 1'b0, "R5", "valid after mid reset", word_valid, 0);
        check(blk_ready === 1'b1, "R5", "ready after mid reset", blk_ready, 1);

        // R6 again from a clean state with control headers
        clear_mon();
        for (int b = 0; b < 8; b++) send_blk(2'b10, {$urandom, $urandom});
        drain();
        check(mon_words == 33, "R6", "words after reset", mon_words, 33);
        check(last_cyc - first_cyc + 1 == 33, "R6", "gapless after reset",
              last_cyc - first_cyc + 1, 33);
        check(hdr_err === 1'b0, "R10", "no err from stalled junk", hdr_err, 0);

        finish_run();
    end

endmodule